// File: doc/BRIEF.md
# Lockstep Output Redundancy Checker

This block sits between a processor core and its output pads so that two identical devices can run in lock step. Each device takes its role from a mode input while reset is held. Once reset is released the role is frozen. A device in the master role drives its pads from the core's computed values and enables. A device in the checker role keeps every output pad undriven and reads back the values the master puts on the shared pins. It compares each enabled bit with its own computed value and reports any difference on an active-low error pin.

The error pin is always driven, in both roles. It has two sources. A pin mismatch produces a one-clock low pulse exactly two clocks after the cycle in which the bad value appeared. An internal array parity error produces a one-clock low pulse on the following cycle, after which the block enters a shutdown state. Shutdown lasts until the next reset. While it lasts, no pads are driven and no further errors are reported.

Top module: `lockstep_checker`

## Requirements
- R1: While `rst_n` is low the role is loaded from `role_sel_i` (0 = master, 1 = checker). After `rst_n` goes high the role does not change, whatever `role_sel_i` does.
- R2: In the master role, outside shutdown, `pad_oe_o` equals `core_oe_i` and `pad_out_o` equals `core_out_i`. Pin differences raise no error.
- R3: In the checker role `pad_oe_o` is all zeros in every cycle. `err_n_o` remains a driven output.
- R4: In the checker role, outside shutdown, suppose that in cycle T some bit with `core_oe_i` set has `pad_in_i` different from `core_out_i`. Then `err_n_o` is low in cycle T+2 and only then, one low cycle per mismatching cycle.
- R5: Bits whose `core_oe_i` is 0 are not compared. A difference on such a bit alone leaves `err_n_o` high.
- R6: Suppose `parity_err_i` is high in cycle T and the block is not in shutdown. Then `err_n_o` is low in cycle T+1 for one cycle, and `shutdown_o` is high from cycle T+2.
- R7: Shutdown is sticky until reset. During shutdown `pad_oe_o` is all zeros and `err_n_o` stays high, even if mismatches or further parity errors arrive.
- R8: After reset, `err_n_o` is high and `shutdown_o` is low.
- R9: A mismatch report and a parity report that fall in the same cycle produce one low cycle on `err_n_o`, and it goes high again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; role is sampled while low |
| role_sel_i | input | 1 | Role select: 0 master, 1 checker |
| core_out_i | input | W | Output values computed by the local core |
| core_oe_i | input | W | Per-bit drive enables computed by the local core |
| pad_in_i | input | W | Values sampled from the shared pins |
| parity_err_i | input | 1 | Internal array parity error |
| pad_out_o | output | W | Values to drive on the pins |
| pad_oe_o | output | W | Per-bit pad drive enables |
| err_n_o | output | 1 | Active-low error indication |
| shutdown_o | output | 1 | High while in shutdown |

## Verification
A pin mismatch and a parity error can both report on the same cycle of the shared error pin. The bench provokes this by placing a mismatch in one cycle and a parity error in the next, so that both reports land on the same later cycle. It then checks that the pin is low for exactly that one cycle, that it is high on the cycle after, and that shutdown follows. A further case lets mismatches arrive after shutdown has begun and checks that none of them reaches the pin.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic {
    ROLE_MASTER  = 1'b0,
    ROLE_CHECKER = 1'b1
  } role_e;
endpackage

// File: rtl/lsc_role_latch.sv
module lsc_role_latch
  import lsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  role_sel_i,
  output role_e role_o
);
  // Follows the select pin during reset, holds afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) role_o <= role_e'(role_sel_i);
  end
endmodule

// File: rtl/lsc_cmp_pipe.sv
module lsc_cmp_pipe #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         flush_i,
  input  logic [W-1:0] core_out_i,
  input  logic [W-1:0] core_oe_i,
  input  logic [W-1:0] pad_in_i,
  output logic         mis_now_o,
  output logic         mis_late_o
);
  function automatic logic differs_f(logic [W-1:0] mine, logic [W-1:0] seen,
                                     logic [W-1:0] mask);
    return |((mine ^ seen) & mask);
  endfunction

  logic [LAT-1:0] stage_q;

  assign mis_now_o = differs_f(core_out_i, pad_in_i, core_oe_i);

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n || flush_i) stage_q <= '0;
        else                   stage_q <= en_i & mis_now_o;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n || flush_i) stage_q <= '0;
        else                   stage_q <= {stage_q[LAT-2:0], en_i & mis_now_o};
      end
    end
  endgenerate

  assign mis_late_o = stage_q[LAT-1];
endmodule

// File: rtl/lsc_fault_ctl.sv
module lsc_fault_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic parity_err_i,
  input  logic mis_late_i,
  output logic par_pulse_o,
  output logic shut_o,
  output logic err_n_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_pulse_o <= 1'b0;
      shut_o      <= 1'b0;
    end else begin
      par_pulse_o <= parity_err_i & ~shut_o & ~par_pulse_o;
      shut_o      <= shut_o | par_pulse_o;
    end
  end

  assign err_n_o = ~((mis_late_i & ~shut_o) | par_pulse_o);
endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker
  import lsc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         role_sel_i,
  input  logic [W-1:0] core_out_i,
  input  logic [W-1:0] core_oe_i,
  input  logic [W-1:0] pad_in_i,
  input  logic         parity_err_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic         err_n_o,
  output logic         shutdown_o
);
  localparam int REPORT_LAT = 2;

  role_e role_q;
  logic  mis_now;
  logic  mis_late;
  logic  par_pulse;
  logic  shut_q;
  logic  cmp_en;

  lsc_role_latch u_role (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_sel_i (role_sel_i),
    .role_o     (role_q)
  );

  assign cmp_en = (role_q == ROLE_CHECKER) && !shut_q;

  lsc_cmp_pipe #(.W(W), .LAT(REPORT_LAT)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cmp_en),
    .flush_i    (shut_q),
    .core_out_i (core_out_i),
    .core_oe_i  (core_oe_i),
    .pad_in_i   (pad_in_i),
    .mis_now_o  (mis_now),
    .mis_late_o (mis_late)
  );

  lsc_fault_ctl u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .parity_err_i (parity_err_i),
    .mis_late_i   (mis_late),
    .par_pulse_o  (par_pulse),
    .shut_o       (shut_q),
    .err_n_o      (err_n_o)
  );

  assign pad_out_o  = core_out_i;
  assign pad_oe_o   = (role_q == ROLE_MASTER && !shut_q) ? core_oe_i : '0;
  assign shutdown_o = shut_q;
endmodule

// File: rtl/lsc_props.sv
module lsc_props
  import lsc_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         parity_err_i,
  input logic [W-1:0] core_oe_i,
  input logic [W-1:0] pad_oe_o,
  input logic         err_n_o,
  input logic         shutdown_o,
  input role_e        role_q,
  input logic         mis_now,
  input logic         par_pulse
);
  p_role_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(role_q));

  p_master_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q == ROLE_MASTER && !shutdown_o) |-> pad_oe_o == core_oe_i);

  p_checker_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q == ROLE_CHECKER) |-> pad_oe_o == '0);

  p_mismatch_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q == ROLE_CHECKER && mis_now && !shutdown_o) ##1 !shutdown_o ##1 !shutdown_o
      |-> !err_n_o);

  p_parity_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err_i && !shutdown_o && !par_pulse) |=> !err_n_o ##1 shutdown_o);

  p_shut_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);

  p_shut_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> (err_n_o && pad_oe_o == '0));
endmodule

bind lockstep_checker lsc_props #(.W(W)) u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .parity_err_i (parity_err_i),
  .core_oe_i    (core_oe_i),
  .pad_oe_o     (pad_oe_o),
  .err_n_o      (err_n_o),
  .shutdown_o   (shutdown_o),
  .role_q       (role_q),
  .mis_now      (mis_now),
  .par_pulse    (par_pulse)
);

// File: tb/tb_lockstep_checker.sv
module tb_lockstep_checker;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         role_sel_i = 1'b0;
  logic [W-1:0] core_out_i = '0;
  logic [W-1:0] core_oe_i = '0;
  logic [W-1:0] pad_in_i = '0;
  logic         parity_err_i = 1'b0;
  logic [W-1:0] pad_out_o;
  logic [W-1:0] pad_oe_o;
  logic         err_n_o;
  logic         shutdown_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lockstep_checker #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .role_sel_i(role_sel_i),
    .core_out_i(core_out_i), .core_oe_i(core_oe_i), .pad_in_i(pad_in_i),
    .parity_err_i(parity_err_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .err_n_o(err_n_o), .shutdown_o(shutdown_o)
  );

  // {enable, computed, seen on pins, expect error}
  localparam logic [3*W:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'hA5, 1'b0},
    {8'hFF, 8'hA5, 8'hA4, 1'b1},
    {8'h0F, 8'h3C, 8'hCC, 1'b0},
    {8'h0F, 8'h3C, 8'h3D, 1'b1},
    {8'h00, 8'hFF, 8'h00, 1'b0},
    {8'h80, 8'h00, 8'h80, 1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] oe, input logic [W-1:0] cv,
                       input logic [W-1:0] pv, input logic par);
    core_oe_i = oe; core_out_i = cv; pad_in_i = pv; parity_err_i = par;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic role);
    rst_n = 1'b0; role_sel_i = role; drive('0, '0, '0, 1'b0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R8 reset state, master role
    do_reset(1'b0);
    chk("R8 err", {7'd0, err_n_o}, 8'd1);
    chk("R8 shutdown", {7'd0, shutdown_o}, 8'd0);

    // R2 master drives and ignores pin differences
    drive(8'h5A, 8'hC3, 8'h00, 1'b0);
    tick();
    chk("R2 oe", pad_oe_o, 8'h5A);
    chk("R2 out", pad_out_o, 8'hC3);
    tick();
    chk("R2 no err", {7'd0, err_n_o}, 8'd1);
    tick();
    chk("R2 no err late", {7'd0, err_n_o}, 8'd1);

    // R6 parity in master role
    drive(8'h5A, 8'hC3, 8'hC3, 1'b1);
    tick();
    chk("R6 pulse", {7'd0, err_n_o}, 8'd0);
    chk("R6 not yet shut", {7'd0, shutdown_o}, 8'd0);
    parity_err_i = 1'b0;
    tick();
    chk("R6 pulse ends", {7'd0, err_n_o}, 8'd1);
    chk("R6 shut", {7'd0, shutdown_o}, 8'd1);
    chk("R7 oe off", pad_oe_o, 8'h00);

    // R1 checker role held after select changes
    do_reset(1'b1);
    role_sel_i = 1'b0;
    drive(8'hFF, 8'h11, 8'h11, 1'b0);
    tick();
    chk("R1 role frozen", pad_oe_o, 8'h00);
    chk("R3 checker quiet", pad_oe_o, 8'h00);
    chk("R8 shut cleared", {7'd0, shutdown_o}, 8'd0);

    // R4 / R5 table walk
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] oe, cv, pv;
      logic         ex;
      {oe, cv, pv, ex} = VEC[i];
      drive(oe, cv, pv, 1'b0);
      tick();
      drive(8'hFF, 8'h00, 8'h00, 1'b0);
      tick();
      chk(ex ? "R4 err at T+2" : "R5 masked/equal", {7'd0, err_n_o}, {7'd0, ~ex});
      tick();
      chk("R4 single pulse", {7'd0, err_n_o}, 8'd1);
      chk("R3 quiet in walk", pad_oe_o, 8'h00);
    end

    // R4 back-to-back mismatches give two low cycles
    drive(8'hFF, 8'h01, 8'h02, 1'b0); tick();
    drive(8'hFF, 8'h01, 8'h03, 1'b0); tick();
    drive(8'hFF, 8'h00, 8'h00, 1'b0);
    chk("R4 first", {7'd0, err_n_o}, 8'd0);
    tick();
    chk("R4 second", {7'd0, err_n_o}, 8'd0);
    tick();
    chk("R4 back high", {7'd0, err_n_o}, 8'd1);

    // R9 coincidence of mismatch and parity reports
    drive(8'hFF, 8'h10, 8'h00, 1'b0); tick();
    drive(8'hFF, 8'h00, 8'h00, 1'b1); tick();
    parity_err_i = 1'b0;
    chk("R9 merged low", {7'd0, err_n_o}, 8'd0);
    tick();
    chk("R9 high after", {7'd0, err_n_o}, 8'd1);
    chk("R9 shut", {7'd0, shutdown_o}, 8'd1);

    // R7 shutdown ignores mismatches and parity
    drive(8'hFF, 8'hAA, 8'h55, 1'b1);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R7 err held high", {7'd0, err_n_o}, 8'd1);
    end
    chk("R7 sticky", {7'd0, shutdown_o}, 8'd1);
    chk("R7 oe off", pad_oe_o, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule